// File: doc/BRIEF.md
# Eight-Lane Multi-Write Dictionary Table

This block is the dictionary of a parallel byte-window compressor. Every cycle a window of eight lanes presents eight lookup addresses and up to eight store requests. Each lookup returns the position pointer and four-byte string that an earlier window left at that address, with a flag that tells whether the entry belongs to the current data block. In the same cycle each lane stores its own pointer and string, so the table always keeps the newest occurrence of each hash.

Storage is one bank per store lane, so all eight stores land in the same cycle with no conflict and no lost update. A per-address live-value table records which bank holds the latest copy of each entry and the block tag under which it was written. A read first consults that table to pick the bank. A block-start pulse moves the current block tag, so all earlier content turns invalid at once without any clearing pass. Tag value zero is kept for entries that have never been written since reset, and the tag counter skips it when it wraps.

Top module: `mwd_table`

## Requirements
- R1: The result of a lookup presented in cycle t appears on the read outputs after the rising edge that ends cycle t, and it holds until the next rising edge.
- R2: A lookup returns valid=1 together with the pointer and string of the most recent store to that address from an earlier window of the current block.
- R3: A lookup in the same cycle as a store to the same address returns the contents from before that store.
- R4: Eight stores to eight distinct addresses in one cycle are all retained.
- R5: When several lanes store to the same address in one cycle, the highest-numbered enabled lane wins (lane 0 lowest, lane 7 highest).
- R6: With the block-start pulse high, the lookups of that same cycle and of every later cycle report invalid for any entry not stored since the pulse. Stores made in the pulse cycle belong to the new block.
- R7: During reset and at the first lookup after reset, every valid flag is 0 and pointers and strings read as zero.
- R8: A lookup that finds no valid entry drives a pointer of zero and a string of zero.
- R9: A lane whose store enable is low changes no entry, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_start | input | 1 | Pulse with the first window of a new data block |
| wr_en | input | LANES | Per-lane store enable, bit i for lane i |
| wr_addr | input | LANES*AW | Per-lane store address, lane i at bits [i*AW +: AW] |
| wr_ptr | input | LANES*PTR_W | Per-lane position pointer to store |
| wr_str | input | LANES*STR_W | Per-lane four-byte string to store |
| rd_addr | input | LANES*AW | Per-lane lookup address |
| rd_valid | output | LANES | Lookup hit an entry of the current block |
| rd_ptr | output | LANES*PTR_W | Looked-up pointer, zero when invalid |
| rd_str | output | LANES*STR_W | Looked-up string, zero when invalid |

## Verification
Every lookup result is due one rising edge after its window is driven. The bench drives each window on a falling edge and compares all eight lanes on the next falling edge, just after the capturing edge and before the next window is applied. The block tag takes effect in the pulse cycle itself, so the expected validity of a window is computed after the model's tag has moved and before the window's own stores are applied to the model. Priority among colliding lanes is modelled by applying stores in ascending lane order, and this makes the last lane win.

// File: rtl/mwd_pkg.sv
`timescale 1ns/1ps
package mwd_pkg;

  // Next block tag: counts up and wraps to 1, since 0 marks never-written entries.
  function automatic int unsigned epoch_advance(input int unsigned cur, input int unsigned width);
    int unsigned top;
    top = (32'd1 << width) - 32'd1;
    return (cur >= top) ? 32'd1 : cur + 32'd1;
  endfunction

  // Flat-vector slice offset for lane/port p of width w.
  function automatic int unsigned lane_base(input int unsigned p, input int unsigned w);
    return p * w;
  endfunction

endpackage

// File: rtl/mwd_bank.sv
`timescale 1ns/1ps
module mwd_bank #(
  parameter int unsigned ENTRIES  = 256,
  parameter int unsigned AW       = 8,
  parameter int unsigned DW       = 48,
  parameter int unsigned RD_PORTS = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [RD_PORTS*AW-1:0]   raddr,
  output logic [RD_PORTS*DW-1:0]   rdata
);

  logic [DW-1:0] mem [ENTRIES];

  // Single write port owned by one lane.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Asynchronous read ports, one per lane; registered in the read mux.
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rdata[p*DW +: DW] = mem[raddr[p*AW +: AW]];
  end

endmodule

// File: rtl/mwd_lvt.sv
`timescale 1ns/1ps
module mwd_lvt #(
  parameter int unsigned LANES   = 8,
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned AW      = 8,
  parameter int unsigned BW      = 3,
  parameter int unsigned EW      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  blk_start,
  input  logic [LANES-1:0]      wr_en,
  input  logic [LANES*AW-1:0]   wr_addr,
  input  logic [LANES*AW-1:0]   rd_addr,
  output logic [LANES*BW-1:0]   rd_bank,
  output logic [LANES-1:0]      rd_live,
  output logic [EW-1:0]         epoch_now
);

  logic [BW-1:0] bank_q [ENTRIES];
  logic [EW-1:0] tag_q  [ENTRIES];
  logic [EW-1:0] epoch_q;
  logic [EW-1:0] epoch_eff;

  logic [ENTRIES-1:0] upd_hit;
  logic [BW-1:0]      upd_bank [ENTRIES];

  // Block tag seen by this window: the pulse takes effect immediately.
  assign epoch_eff = blk_start ? EW'(mwd_pkg::epoch_advance(32'(epoch_q), EW)) : epoch_q;
  assign epoch_now = epoch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) epoch_q <= EW'(1);
    else        epoch_q <= epoch_eff;
  end

  // Per-address priority: a later lane overrides an earlier one.
  always_comb begin
    for (int a = 0; a < ENTRIES; a++) begin
      upd_hit[a]  = 1'b0;
      upd_bank[a] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (wr_en[l] && (wr_addr[l*AW +: AW] == AW'(a))) begin
          upd_hit[a]  = 1'b1;
          upd_bank[a] = BW'(l);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < ENTRIES; a++) begin
        bank_q[a] <= '0;
        tag_q[a]  <= '0;
      end
    end else begin
      for (int a = 0; a < ENTRIES; a++) begin
        if (upd_hit[a]) begin
          bank_q[a] <= upd_bank[a];
          tag_q[a]  <= epoch_eff;
        end
      end
    end
  end

  // Lookup side sees state from before this window's updates.
  for (genvar l = 0; l < LANES; l++) begin : g_look
    logic [AW-1:0] ra;
    assign ra                  = rd_addr[l*AW +: AW];
    assign rd_bank[l*BW +: BW] = bank_q[ra];
    assign rd_live[l]          = (tag_q[ra] == epoch_eff);
  end

endmodule

// File: rtl/mwd_rdmux.sv
`timescale 1ns/1ps
module mwd_rdmux #(
  parameter int unsigned LANES = 8,
  parameter int unsigned BW    = 3,
  parameter int unsigned PTR_W = 16,
  parameter int unsigned STR_W = 32,
  localparam int unsigned DW   = PTR_W + STR_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES*BW-1:0]         sel,
  input  logic [LANES-1:0]            live,
  input  logic [LANES*LANES*DW-1:0]   bank_rd,
  output logic [LANES-1:0]            rd_valid,
  output logic [LANES*PTR_W-1:0]      rd_ptr,
  output logic [LANES*STR_W-1:0]      rd_str
);

  logic [DW-1:0] pick [LANES];

  for (genvar p = 0; p < LANES; p++) begin : g_pick
    logic [BW-1:0] b;
    assign b       = sel[p*BW +: BW];
    assign pick[p] = bank_rd[(int'(b) * LANES + p) * DW +: DW];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_valid[p]               <= 1'b0;
        rd_ptr[p*PTR_W +: PTR_W]  <= '0;
        rd_str[p*STR_W +: STR_W]  <= '0;
      end else begin
        rd_valid[p]               <= live[p];
        rd_ptr[p*PTR_W +: PTR_W]  <= live[p] ? pick[p][DW-1 -: PTR_W] : '0;
        rd_str[p*STR_W +: STR_W]  <= live[p] ? pick[p][STR_W-1:0]     : '0;
      end
    end
  end

endmodule

// File: rtl/mwd_table.sv
`timescale 1ns/1ps
module mwd_table #(
  parameter int unsigned LANES   = 8,
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned PTR_W   = 16,
  parameter int unsigned STR_W   = 32,
  parameter int unsigned EPOCH_W = 4,
  localparam int unsigned AW     = $clog2(ENTRIES),
  localparam int unsigned BW     = $clog2(LANES),
  localparam int unsigned DW     = PTR_W + STR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    blk_start,
  input  logic [LANES-1:0]        wr_en,
  input  logic [LANES*AW-1:0]     wr_addr,
  input  logic [LANES*PTR_W-1:0]  wr_ptr,
  input  logic [LANES*STR_W-1:0]  wr_str,
  input  logic [LANES*AW-1:0]     rd_addr,
  output logic [LANES-1:0]        rd_valid,
  output logic [LANES*PTR_W-1:0]  rd_ptr,
  output logic [LANES*STR_W-1:0]  rd_str
);

  logic [LANES*LANES*DW-1:0] bank_rd;
  logic [LANES*BW-1:0]       look_bank;
  logic [LANES-1:0]          look_live;
  logic [EPOCH_W-1:0]        epoch_now;

  // One storage bank per store lane.
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    mwd_bank #(
      .ENTRIES (ENTRIES),
      .AW      (AW),
      .DW      (DW),
      .RD_PORTS(LANES)
    ) u_bank (
      .clk  (clk),
      .we   (wr_en[b]),
      .waddr(wr_addr[b*AW +: AW]),
      .wdata({wr_ptr[b*PTR_W +: PTR_W], wr_str[b*STR_W +: STR_W]}),
      .raddr(rd_addr),
      .rdata(bank_rd[b*LANES*DW +: LANES*DW])
    );
  end

  mwd_lvt #(
    .LANES  (LANES),
    .ENTRIES(ENTRIES),
    .AW     (AW),
    .BW     (BW),
    .EW     (EPOCH_W)
  ) u_lvt (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk_start(blk_start),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .rd_bank  (look_bank),
    .rd_live  (look_live),
    .epoch_now(epoch_now)
  );

  mwd_rdmux #(
    .LANES(LANES),
    .BW   (BW),
    .PTR_W(PTR_W),
    .STR_W(STR_W)
  ) u_rdmux (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (look_bank),
    .live    (look_live),
    .bank_rd (bank_rd),
    .rd_valid(rd_valid),
    .rd_ptr  (rd_ptr),
    .rd_str  (rd_str)
  );

endmodule

// File: rtl/mwd_table_chk.sv
`timescale 1ns/1ps
module mwd_table_chk #(
  parameter int unsigned LANES   = 8,
  parameter int unsigned AW      = 8,
  parameter int unsigned PTR_W   = 16,
  parameter int unsigned STR_W   = 32,
  parameter int unsigned EPOCH_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    blk_start,
  input  logic                    top_wen,
  input  logic [AW-1:0]           top_waddr,
  input  logic [PTR_W-1:0]        top_wptr,
  input  logic [STR_W-1:0]        top_wstr,
  input  logic [AW-1:0]           rd0_addr,
  input  logic [LANES-1:0]        rd_valid,
  input  logic [LANES*PTR_W-1:0]  rd_ptr,
  input  logic [LANES*STR_W-1:0]  rd_str,
  input  logic [EPOCH_W-1:0]      epoch_now
);

  // R6: lookups made in a pulse cycle never hit.
  a_r6_pulse_clears: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> (rd_valid == '0));

  // R6: the block tag moves on every pulse and only then.
  a_r6_tag_moves: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> (epoch_now != $past(epoch_now)));

  a_r6_tag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_start |=> $stable(epoch_now));

  // R6: tag zero is reserved for never-written entries.
  a_r6_tag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_now != '0);

  // R5 / R2: a store by the top lane is always seen by the next window's lookup.
  a_r5_top_lane_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (top_wen && !blk_start) ##1 (!blk_start && (rd0_addr == $past(top_waddr)))
    |=> (rd_valid[0] && (rd_ptr[PTR_W-1:0] == $past(top_wptr, 2))
                     && (rd_str[STR_W-1:0] == $past(top_wstr, 2))));

  // R8: misses read as zero on every lane.
  for (genvar l = 0; l < LANES; l++) begin : g_miss
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid[l] |-> ((rd_ptr[l*PTR_W +: PTR_W] == '0) && (rd_str[l*STR_W +: STR_W] == '0)));
  end

  // R7: flags never unknown once out of reset.
  a_r7_flags_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(rd_valid));

endmodule

bind mwd_table mwd_table_chk #(
  .LANES  (LANES),
  .AW     (AW),
  .PTR_W  (PTR_W),
  .STR_W  (STR_W),
  .EPOCH_W(EPOCH_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .blk_start(blk_start),
  .top_wen  (wr_en[LANES-1]),
  .top_waddr(wr_addr[(LANES-1)*AW +: AW]),
  .top_wptr (wr_ptr[(LANES-1)*PTR_W +: PTR_W]),
  .top_wstr (wr_str[(LANES-1)*STR_W +: STR_W]),
  .rd0_addr (rd_addr[AW-1:0]),
  .rd_valid (rd_valid),
  .rd_ptr   (rd_ptr),
  .rd_str   (rd_str),
  .epoch_now(epoch_now)
);

// File: tb/mwd_table_test.sv
`timescale 1ns/1ps
module mwd_table_test;
  localparam int L  = 8;
  localparam int N  = 256;
  localparam int AW = 8;
  localparam int PW = 16;
  localparam int SW = 32;
  localparam int EW = 4;

  typedef logic [AW-1:0] addr_t [L];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_start = 1'b0;
  logic [L-1:0]    wr_en = '0;
  logic [L*AW-1:0] wr_addr = '0;
  logic [L*AW-1:0] rd_addr = '0;
  logic [L*PW-1:0] wr_ptr = '0;
  logic [L*SW-1:0] wr_str = '0;
  logic [L-1:0]    rd_valid;
  logic [L*PW-1:0] rd_ptr;
  logic [L*SW-1:0] rd_str;

  mwd_table #(.LANES(L), .ENTRIES(N), .PTR_W(PW), .STR_W(SW), .EPOCH_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_ptr(wr_ptr), .wr_str(wr_str),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_ptr(rd_ptr), .rd_str(rd_str)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference: one copy per address, block number per entry.
  int            m_blk [N];
  logic [PW-1:0] m_ptr [N];
  logic [SW-1:0] m_str [N];
  int            m_cur = 1;
  int            seq = 0;

  logic          e_v [L];
  logic [PW-1:0] e_p [L];
  logic [SW-1:0] e_s [L];
  string         e_tag [L];
  bit            pend = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // {pulse, enables, store base, store step, lookup base, lookup step}
  localparam logic [40:0] VEC [11] = '{
    {1'b1, 8'hFF, 8'h10, 8'h01, 8'h10, 8'h01},
    {1'b0, 8'h00, 8'h00, 8'h00, 8'h10, 8'h01},
    {1'b0, 8'hFF, 8'h40, 8'h00, 8'h40, 8'h00},
    {1'b0, 8'h0F, 8'h80, 8'h03, 8'h40, 8'h00},
    {1'b0, 8'hF0, 8'h10, 8'h01, 8'h80, 8'h03},
    {1'b0, 8'h00, 8'h00, 8'h00, 8'h10, 8'h01},
    {1'b1, 8'h00, 8'h00, 8'h00, 8'h10, 8'h01},
    {1'b0, 8'hAA, 8'h10, 8'h02, 8'h10, 8'h02},
    {1'b0, 8'h00, 8'h00, 8'h00, 8'h10, 8'h02},
    {1'b0, 8'hFF, 8'hF8, 8'h01, 8'hF8, 8'h01},
    {1'b0, 8'h00, 8'h00, 8'h00, 8'hF8, 8'h01}
  };

  function automatic logic [PW-1:0] gen_ptr(input int s, input int l);
    return PW'(32'h0100 + s * 8 + l);
  endfunction

  function automatic logic [SW-1:0] gen_str(input int s, input int l);
    return {8'(s), 8'(l), 16'(s * 37 + l) ^ 16'hBEEF};
  endfunction

  function automatic addr_t mk_addr(input logic [7:0] base, input logic [7:0] step);
    addr_t r;
    for (int l = 0; l < L; l++) r[l] = AW'(int'(base) + l * int'(step));
    return r;
  endfunction

  function automatic addr_t same_addr(input logic [7:0] a);
    addr_t r;
    for (int l = 0; l < L; l++) r[l] = a;
    return r;
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_pending();
    if (pend) begin
      for (int l = 0; l < L; l++) begin
        check(e_tag[l], $sformatf("lane%0d valid", l), 64'(rd_valid[l]), 64'(e_v[l]));
        check(e_tag[l], $sformatf("lane%0d ptr", l), 64'(rd_ptr[l*PW +: PW]), 64'(e_p[l]));
        check(e_tag[l], $sformatf("lane%0d str", l), 64'(rd_str[l*SW +: SW]), 64'(e_s[l]));
      end
    end
    pend = 1'b0;
  endtask

  // Drive one window on a falling edge; its results are checked one edge later.
  task automatic run_window(input bit b, input logic [L-1:0] en, input addr_t wa,
                            input addr_t ra, input string tag);
    @(negedge clk);
    check_pending();
    if (b) m_cur++;
    for (int l = 0; l < L; l++) begin
      e_v[l] = (m_blk[ra[l]] == m_cur);
      e_p[l] = e_v[l] ? m_ptr[ra[l]] : '0;
      e_s[l] = e_v[l] ? m_str[ra[l]] : '0;
      if (tag != "")     e_tag[l] = tag;
      else if (b)        e_tag[l] = "R6";
      else if (e_v[l])   e_tag[l] = "R2";
      else               e_tag[l] = "R8";
      wr_addr[l*AW +: AW] = wa[l];
      rd_addr[l*AW +: AW] = ra[l];
      wr_ptr[l*PW +: PW]  = gen_ptr(seq, l);
      wr_str[l*SW +: SW]  = gen_str(seq, l);
    end
    wr_en = en;
    blk_start = b;
    for (int l = 0; l < L; l++) begin
      if (en[l]) begin
        m_blk[wa[l]] = m_cur;
        m_ptr[wa[l]] = gen_ptr(seq, l);
        m_str[wa[l]] = gen_str(seq, l);
      end
    end
    seq++;
    pend = 1'b1;
  endtask

  initial begin
    for (int a = 0; a < N; a++) begin
      m_blk[a] = 0;
      m_ptr[a] = '0;
      m_str[a] = '0;
    end

    // R7: outputs held at zero during reset.
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7", "valid in reset", 64'(rd_valid), 64'd0);
      check("R7", "ptr in reset", 64'(rd_ptr[PW-1:0]), 64'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R7: first lookups after reset miss everywhere.
    run_window(1'b0, 8'h00, same_addr(8'h00), mk_addr(8'h00, 8'h21), "R7");

    // Vector table.
    for (int i = 0; i < 11; i++) begin
      run_window(VEC[i][40], VEC[i][39:32], mk_addr(VEC[i][31:24], VEC[i][23:16]),
                 mk_addr(VEC[i][15:8], VEC[i][7:0]), "");
    end

    // R3: same-cycle store and lookup returns the old contents.
    run_window(1'b0, 8'h01, same_addr(8'h30), same_addr(8'h30), "R3");
    run_window(1'b0, 8'h04, same_addr(8'h30), same_addr(8'h30), "R3");
    // R1: the store of the previous window shows exactly one edge later.
    run_window(1'b0, 8'h00, same_addr(8'h30), same_addr(8'h30), "R1");

    // R4: eight distinct stores, all retained.
    run_window(1'b0, 8'hFF, mk_addr(8'hA0, 8'h05), same_addr(8'h00), "");
    run_window(1'b0, 8'h00, same_addr(8'h00), mk_addr(8'hA0, 8'h05), "R4");

    // R5: lanes 0..6 collide, lane 7 disabled, so lane 6 wins.
    run_window(1'b0, 8'h7F, same_addr(8'h50), same_addr(8'h00), "");
    run_window(1'b0, 8'h00, same_addr(8'h00), same_addr(8'h50), "R5");

    // R9: disabled lanes aimed at a live entry leave it untouched.
    run_window(1'b0, 8'h08, same_addr(8'h60), same_addr(8'h00), "");
    run_window(1'b0, 8'h00, same_addr(8'h60), mk_addr(8'h60, 8'h01), "R9");
    run_window(1'b0, 8'h00, same_addr(8'h60), same_addr(8'h60), "R9");

    // R6: a new block hides the entry just confirmed live.
    run_window(1'b1, 8'h00, same_addr(8'h00), same_addr(8'h60), "R6");
    run_window(1'b0, 8'h00, same_addr(8'h00), mk_addr(8'h50, 8'h10), "R6");

    // Flush the last window.
    run_window(1'b0, 8'h00, same_addr(8'h00), same_addr(8'h00), "");
    @(negedge clk);
    check_pending();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule